// File: doc/BRIEF.md
# ADC-Driven FM Tuning Controller

This block steers the frequency of a synthesizer from an analog message signal. The host loads two words through separate strobed ports: a center tuning word and a deviation scale. A free-running timer asks an external ADC for a conversion at a fixed rate, nominally once per microsecond. Each returned signed sample becomes a new 32-bit tuning word: the center plus the sample-scaled deviation, clamped to the unsigned range. The word is offered at once to the synthesizer programming logic over a valid/ready port.

The deviation word sets how far the tuning word moves when the input is at positive full scale. The trigger period is a clock-divider parameter, so a 100 MHz system clock with a divider of 100 gives the 1 MHz rate. The enable input gates the whole path. While it is low, no conversions are requested and the output word rests on the center word.

Back-pressure rules for the update port: the block raises valid with a word and holds both until ready is seen high at a clock edge. If a new sample arrives while the word is still pending, the new result replaces it and valid stays high. Only the newest word matters to the synthesizer. The downstream side must therefore not rely on the word staying stable across a pending period that spans a sample.

Top module: `fm_tune_ctrl`

## Requirements
- R1: After reset, adc_convert and upd_valid are low and upd_ftw is zero.
- R2: While enable is high, adc_convert is a one-cycle pulse repeating exactly every CLK_DIV cycles.
- R3: A cycle with adc_ready and enable high takes adc_data, which is 12-bit two's complement. In the next cycle upd_valid is high and upd_ftw equals center + floor(sample × deviation / 2^11), where center and deviation are unsigned 32-bit.
- R4: A sum above 2^32−1 gives upd_ftw = 0xFFFFFFFF.
- R5: A negative sum gives upd_ftw = 0.
- R6: While upd_valid is high, upd_ready is low and no sample is taken, upd_valid and upd_ftw hold. After an edge with upd_ready high and no new sample, upd_valid is low.
- R7: A sample taken while a word is pending replaces it: upd_valid stays high with the new word.
- R8: While enable is low, adc_convert stays low and adc_ready is ignored. From the next cycle, upd_valid is low and upd_ftw equals the loaded center word.
- R9: center_we and dev_we load their words independently. The next sample uses the values loaded before it.
- R10: A sample taken in the same cycle as an accepted transfer leaves upd_valid high, carrying the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Gates triggering and sample intake |
| center_we | input | 1 | Load strobe for the center word |
| center_in | input | 32 | Center tuning word |
| dev_we | input | 1 | Load strobe for the deviation word |
| dev_in | input | 32 | Deviation at positive full-scale input |
| adc_convert | output | 1 | One-cycle conversion request |
| adc_ready | input | 1 | ADC result valid this cycle |
| adc_data | input | 12 | Signed ADC sample |
| upd_valid | output | 1 | Tuning word pending |
| upd_ready | input | 1 | Synthesizer programming logic accepts |
| upd_ftw | output | 32 | Tuning word |

## Verification
The bench builds the block with CLK_DIV = 8. With that value the trigger spacing and pulse width can be measured over several periods in a few dozen cycles. All 4096 sample codes are swept under three center/deviation pairs, and one pair is chosen so that both clamping limits and the unclamped region between them are crossed in a single sweep. Directed sequences then drive the handshake into holding, overwrite, simultaneous accept-and-replace, and the disabled state.

// File: rtl/fm_tune_pkg.sv
package fm_tune_pkg;
  localparam int FTW_W    = 32;
  localparam int SAMPLE_W = 12;
  typedef logic        [FTW_W-1:0]    ftw_t;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/fm_tune_regs.sv
module fm_tune_regs
  import fm_tune_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic center_we,
  input  ftw_t center_in,
  input  logic dev_we,
  input  ftw_t dev_in,
  output ftw_t center_q,
  output ftw_t dev_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      center_q <= '0;
      dev_q    <= '0;
    end else begin
      if (center_we) center_q <= center_in;
      if (dev_we)    dev_q    <= dev_in;
    end
  end

  // R9: a strobe lands its word at the next edge
  p_center_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    center_we |=> center_q == $past(center_in));
  p_dev_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_we |=> dev_q == $past(dev_in));
endmodule

// File: rtl/fm_trigger_timer.sv
module fm_trigger_timer #(
  parameter int CLK_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic convert
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt     <= '0;
      convert <= 1'b0;
    end else begin
      cnt     <= (cnt == LAST) ? '0 : cnt + 1'b1;
      convert <= (cnt == LAST);
    end
  end

  // R2: single-cycle pulse, counter within its period
  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    convert |=> !convert);
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R8: nothing requested while disabled
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !convert);
endmodule

// File: rtl/fm_ftw_calc.sv
module fm_ftw_calc
  import fm_tune_pkg::*;
(
  input  sample_t sample,
  input  ftw_t    center,
  input  ftw_t    dev,
  output ftw_t    ftw
);
  localparam int PROD_W = SAMPLE_W + FTW_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SHIFT  = SAMPLE_W - 1;

  logic signed [PROD_W-1:0] s_ext, d_ext, prod, step;
  logic        [SUM_W-1:0]  sum;

  always_comb begin
    s_ext = PROD_W'(sample);
    d_ext = PROD_W'({1'b0, dev});
    prod  = s_ext * d_ext;
    step  = prod >>> SHIFT;
    sum   = SUM_W'(step) + SUM_W'({1'b0, center});
    if (sum[SUM_W-1])                 ftw = '0;
    else if (|sum[SUM_W-2:FTW_W])     ftw = '1;
    else                              ftw = sum[FTW_W-1:0];
  end
endmodule

// File: rtl/fm_update_slot.sv
module fm_update_slot
  import fm_tune_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic take,
  input  ftw_t result,
  input  ftw_t center,
  input  logic upd_ready,
  output logic upd_valid,
  output ftw_t upd_ftw
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_ftw   <= '0;
    end else if (!enable) begin
      upd_valid <= 1'b0;
      upd_ftw   <= center;
    end else if (take) begin
      upd_valid <= 1'b1;
      upd_ftw   <= result;
    end else if (upd_valid && upd_ready) begin
      upd_valid <= 1'b0;
    end
  end

  // R6: pending word held under back-pressure
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && upd_valid && !upd_ready && !take) |=> (upd_valid && $stable(upd_ftw)));
  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && upd_valid && upd_ready && !take) |=> !upd_valid);
  // R8: disabled output rests on center
  p_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!upd_valid && upd_ftw == $past(center)));
endmodule

// File: rtl/fm_tune_ctrl.sv
module fm_tune_ctrl
  import fm_tune_pkg::*;
#(
  parameter int CLK_DIV = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                center_we,
  input  logic [FTW_W-1:0]    center_in,
  input  logic                dev_we,
  input  logic [FTW_W-1:0]    dev_in,
  output logic                adc_convert,
  input  logic                adc_ready,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic                upd_valid,
  input  logic                upd_ready,
  output logic [FTW_W-1:0]    upd_ftw
);
  ftw_t center_q, dev_q, result;
  logic take;

  assign take = adc_ready && enable;

  fm_tune_regs i_regs (
    .clk(clk), .rst_n(rst_n),
    .center_we(center_we), .center_in(center_in),
    .dev_we(dev_we), .dev_in(dev_in),
    .center_q(center_q), .dev_q(dev_q)
  );

  fm_trigger_timer #(.CLK_DIV(CLK_DIV)) i_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .convert(adc_convert)
  );

  fm_ftw_calc i_calc (
    .sample(sample_t'(adc_data)), .center(center_q), .dev(dev_q), .ftw(result)
  );

  fm_update_slot i_slot (
    .clk(clk), .rst_n(rst_n), .enable(enable), .take(take),
    .result(result), .center(center_q), .upd_ready(upd_ready),
    .upd_valid(upd_valid), .upd_ftw(upd_ftw)
  );

  // R3 / R7 / R10: every taken sample yields a pending word next cycle
  p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> upd_valid);
  // R3: zero deviation leaves the center word
  p_zero_dev_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dev_q == '0) |=> upd_ftw == $past(center_q));
endmodule

// File: tb/test_fm_tune_ctrl.sv
module test_fm_tune_ctrl;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        center_we = 1'b0, dev_we = 1'b0;
  logic [31:0] center_in = '0, dev_in = '0;
  logic        adc_convert;
  logic        adc_ready = 1'b0;
  logic [11:0] adc_data = '0;
  logic        upd_valid;
  logic        upd_ready = 1'b1;
  logic [31:0] upd_ftw;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fm_tune_ctrl #(.CLK_DIV(DIV)) i_fm_tune_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .center_we(center_we), .center_in(center_in),
    .dev_we(dev_we), .dev_in(dev_in),
    .adc_convert(adc_convert), .adc_ready(adc_ready), .adc_data(adc_data),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_ftw(upd_ftw)
  );

  function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] d,
                                        input logic [11:0] s);
    longint sv, dv, cv, q;
    sv = longint'($signed(s));
    dv = longint'({32'b0, d});
    cv = longint'({32'b0, c});
    q  = cv + ((sv * dv) >>> 11);
    if (q < 0) return 32'h0;
    if (q > 64'sh0FFFF_FFFF) return 32'hFFFF_FFFF;
    return q[31:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] c, input logic [31:0] d);
    @(negedge clk);
    center_we = 1'b1; center_in = c;
    dev_we = 1'b1; dev_in = d;
    @(negedge clk);
    center_we = 1'b0; dev_we = 1'b0;
  endtask

  task automatic sample(input logic [11:0] s);
    @(negedge clk);
    adc_ready = 1'b1; adc_data = s;
    @(negedge clk);
    adc_ready = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] cs [3];
    logic [31:0] ds [3];
    int last, gap;
    cs[0] = 32'h8000_0000; ds[0] = 32'h0000_1000;
    cs[1] = 32'h1234_5678; ds[1] = 32'h07FF_FFFF;
    cs[2] = 32'h4000_0000; ds[2] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    check("R1 convert", adc_convert, 0);
    check("R1 valid", upd_valid, 0);
    check("R1 ftw", upd_ftw, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ftw after release", upd_ftw, 0);

    // R2: pulse width and spacing
    enable = 1'b1;
    last = -1;
    for (int i = 0; i < 6 * DIV; i++) begin
      @(negedge clk);
      if (adc_convert) begin
        if (last >= 0) check("R2 period", i - last, DIV);
        last = i;
      end
    end
    check("R2 pulses seen", last >= 0, 1);

    // R3/R4/R5/R9: full sample sweep under three settings
    for (int k = 0; k < 3; k++) begin
      load(cs[k], ds[k]);
      for (int s = 0; s < 4096; s++) begin
        sample(12'(s));
        check("R3 valid", upd_valid, 1);
        check("R3/R4/R5 ftw", upd_ftw, model(cs[k], ds[k], 12'(s)));
      end
    end

    // R4 / R5 boundary values
    load(32'hFFFF_FF00, 32'hFFFF_FFFF);
    sample(12'h7FF);
    check("R4 clamp high", upd_ftw, 32'hFFFF_FFFF);
    load(32'h0000_0010, 32'h0000_1000);
    sample(12'h800);
    check("R5 clamp low", upd_ftw, 32'h0);

    // R9: independent loads, next sample uses new deviation
    @(negedge clk); dev_we = 1'b1; dev_in = 32'h0000_0800;
    @(negedge clk); dev_we = 1'b0;
    sample(12'h100);
    check("R9 new deviation", upd_ftw, model(32'h10, 32'h800, 12'h100));

    // R6: hold under back-pressure, then drop after accept
    @(negedge clk); upd_ready = 1'b0;
    sample(12'h010);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 hold valid", upd_valid, 1);
      check("R6 hold ftw", upd_ftw, model(32'h10, 32'h800, 12'h010));
    end
    upd_ready = 1'b1;
    @(negedge clk);
    check("R6 drop", upd_valid, 0);

    // R7: overwrite while pending
    upd_ready = 1'b0;
    sample(12'h020);
    sample(12'h030);
    check("R7 valid", upd_valid, 1);
    check("R7 newest", upd_ftw, model(32'h10, 32'h800, 12'h030));

    // R10: accept and new sample in the same cycle
    @(negedge clk);
    upd_ready = 1'b1; adc_ready = 1'b1; adc_data = 12'h040;
    @(negedge clk);
    adc_ready = 1'b0;
    check("R10 valid", upd_valid, 1);
    check("R10 ftw", upd_ftw, model(32'h10, 32'h800, 12'h040));
    @(negedge clk);
    check("R10 drained", upd_valid, 0);

    // R8: disabled behaviour
    @(negedge clk); enable = 1'b0;
    center_we = 1'b1; center_in = 32'h2222_3333;
    @(negedge clk); center_we = 1'b0;
    @(negedge clk);
    check("R8 rest on center", upd_ftw, 32'h2222_3333);
    check("R8 valid low", upd_valid, 0);
    sample(12'h7FF);
    check("R8 sample ignored valid", upd_valid, 0);
    check("R8 sample ignored ftw", upd_ftw, 32'h2222_3333);
    gap = 0;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (adc_convert) gap++;
    end
    check("R8 no convert", gap, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule